// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits in an HDLC receiver behind flag removal and zero-bit destuffing. It accepts received bytes one at a time. Each byte comes with a frame-start marker on the first byte after the opening flag and a frame-end marker on the last byte of the frame. A 3-bit mode input selects how the frame's leading bytes are recognised: full one- or two-byte address recognition, a TEI-only compare, a SAPI-only compare with group values, pass-all, or reserved.

Four programmable compare values are held outside the block: two SAPI values and two TEI values. Every byte of an accepted frame goes to one of three places:

- an address capture strobe,
- a control capture strobe,
- the write port of a receive FIFO.

A frame that fails recognition leaves no trace on any of these outputs. After the last byte of each frame, a status word reports whether the frame matched, which comparator hit, and whether a one-byte address marked the frame as a command.

Top module: `hdlc_rx_addr_filter`

## Requirements
- R1: While reset (active-low, synchronous) is applied and in the first cycle after it, `addr_we`, `ctrl_we`, `fifo_we` and `stat_valid` are 0, and `stat_match`, `stat_hit` and `stat_cmd` are 0.
- R2: A byte is taken when `in_valid` is 1 and either `in_sof` is 1 or a frame is open. The byte carrying `in_eof` closes the frame. A valid byte that arrives outside an open frame and without `in_sof` produces no write strobe and no status.
- R3: Every write strobe rises exactly one clock cycle after the byte that causes it is taken. At most one of `addr_we`, `ctrl_we` and `fifo_we` is high in any cycle.
- R4: In mode 3'b110, every byte of the frame is written to the FIFO in order, and the status reports a match with hit code 7.
- R5: In mode 3'b111, the first byte is compared, all 8 bits, against `sap1`, `sap2`, 0xFE and 0xFC. On a match, every later byte is written to the FIFO and nothing goes to the address or control strobes.
- R6: In mode 3'b101, only the second byte is compared, all 8 bits, against `tei1`, `tei2` and 0xFF. On a match, the first byte appears on `addr_data` with `addr_we` one cycle after the second byte. The third byte goes to the control strobe, and later bytes go to the FIFO.
- R7: In any mode with bit 2 equal to 0 (full recognition), bit 0 of the first byte selects the address length: 1 means a one-byte address and 0 means a two-byte address. The address bytes themselves are never written.
- R8: With a one-byte address, the byte is compared, all 8 bits, against `tei1` and `tei2` (no group value). A `tei1` hit sets `stat_cmd` to 1 and a `tei2` hit sets it to 0. The next byte goes to the control strobe, and later bytes go to the FIFO.
- R9: With a two-byte address, bits 7:2 of the first byte must equal bits 7:2 of `sap1` or `sap2`, and the second byte must equal `tei1`, `tei2` or 0xFF. The third byte goes to the control strobe and later bytes go to the FIFO. The reported hit is that of the second byte.
- R10: A frame that fails its compare, or that ends before the compared byte arrives, produces no address, control or FIFO write. Its status has `stat_match`=0 and `stat_hit`=0.
- R11: `stat_valid` pulses for one cycle, one cycle after the end byte is taken. `stat_match`, `stat_hit` and `stat_cmd` then hold until the next frame end. Hit codes: 0 none, 1 `sap1`, 2 `sap2`, 3 group SAPI, 4 `tei1`, 5 `tei2`, 6 group TEI, 7 pass-all. Priority is `sap1` over `sap2` over group, and `tei1` over `tei2` over group. `stat_cmd` is 1 only with hit code 4 from a one-byte address.
- R12: Mode 3'b100 is reserved. Every frame in this mode is discarded as in R10.
- R13: The mode is sampled on the start byte. A change of `mode` during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Received byte present |
| in_sof | input | 1 | Byte is the first after the opening flag |
| in_eof | input | 1 | Byte is the last of the frame |
| in_data | input | 8 | Received byte |
| mode | input | 3 | Recognition mode, sampled on the start byte |
| sap1 | input | 8 | First SAPI compare value |
| sap2 | input | 8 | Second SAPI compare value |
| tei1 | input | 8 | First TEI compare value (command) |
| tei2 | input | 8 | Second TEI compare value (response) |
| addr_we | output | 1 | Address capture strobe |
| addr_data | output | 8 | Captured address byte |
| ctrl_we | output | 1 | Control capture strobe |
| ctrl_data | output | 8 | Captured control byte |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| stat_valid | output | 1 | Frame status pulse |
| stat_match | output | 1 | Frame was accepted |
| stat_hit | output | 3 | Comparator hit code |
| stat_cmd | output | 1 | One-byte address matched the command TEI |

## Verification
A wrong byte index or a stale decision shows up as a byte steered to the wrong strobe, or as a strobe for a rejected frame. Either appears one cycle after the offending byte. A latched first byte that was captured at the wrong time shows as a wrong `addr_data` value one cycle after the second byte of a TEI-mode frame. A mode that is resampled mid-frame, or a decision flag not cleared at frame start, changes the routing of later bytes and the status that pulses one cycle after the end byte. That makes each frame's status the latest point at which such an error becomes visible.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [2:0] MODE_RSVD = 3'b100;
  localparam logic [2:0] MODE_TEI  = 3'b101;
  localparam logic [2:0] MODE_PASS = 3'b110;
  localparam logic [2:0] MODE_SAPI = 3'b111;

  typedef enum logic [2:0] {
    HIT_NONE  = 3'd0,
    HIT_SAP1  = 3'd1,
    HIT_SAP2  = 3'd2,
    HIT_GSAPI = 3'd3,
    HIT_TEI1  = 3'd4,
    HIT_TEI2  = 3'd5,
    HIT_GTEI  = 3'd6,
    HIT_ALL   = 3'd7
  } hit_e;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_ADDR = 2'd1,
    RT_CTRL = 2'd2,
    RT_FIFO = 2'd3
  } route_e;

  // SAPI compare: the masked form ignores the C/R and extension bits
  function automatic hit_e sapi_hit_f(input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-1:0] s1,
                                      input logic [BYTE_W-1:0] s2,
                                      input logic [BYTE_W-1:0] g1,
                                      input logic [BYTE_W-1:0] g2,
                                      input logic masked,
                                      input logic use_grp);
    logic [BYTE_W-1:0] m;
    m = masked ? {{(BYTE_W-2){1'b1}}, 2'b00} : {BYTE_W{1'b1}};
    if ((b & m) == (s1 & m))             return HIT_SAP1;
    if ((b & m) == (s2 & m))             return HIT_SAP2;
    if (use_grp && (b == g1 || b == g2)) return HIT_GSAPI;
    return HIT_NONE;
  endfunction

  function automatic hit_e tei_hit_f(input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-1:0] t1,
                                     input logic [BYTE_W-1:0] t2,
                                     input logic [BYTE_W-1:0] g,
                                     input logic use_grp);
    if (b == t1)             return HIT_TEI1;
    if (b == t2)             return HIT_TEI2;
    if (use_grp && b == g)   return HIT_GTEI;
    return HIT_NONE;
  endfunction
endpackage

// File: rtl/hdlc_af_sapi_cmp.sv
module hdlc_af_sapi_cmp
  import hdlc_af_pkg::*;
#(
  parameter int unsigned W = BYTE_W,
  parameter logic [W-1:0] GRP_A = 8'hFE,
  parameter logic [W-1:0] GRP_B = 8'hFC
) (
  input  logic [W-1:0] byte_in,
  input  logic [W-1:0] sap1,
  input  logic [W-1:0] sap2,
  input  logic         masked,
  input  logic         use_grp,
  output hit_e         hit
);
  assign hit = sapi_hit_f(byte_in, sap1, sap2, GRP_A, GRP_B, masked, use_grp);
endmodule

// File: rtl/hdlc_af_tei_cmp.sv
module hdlc_af_tei_cmp
  import hdlc_af_pkg::*;
#(
  parameter int unsigned W = BYTE_W,
  parameter logic [W-1:0] GRP = 8'hFF
) (
  input  logic [W-1:0] byte_in,
  input  logic [W-1:0] tei1,
  input  logic [W-1:0] tei2,
  input  logic         use_grp,
  output hit_e         hit
);
  assign hit = tei_hit_f(byte_in, tei1, tei2, GRP, use_grp);
endmodule

// File: rtl/hdlc_af_router.sv
module hdlc_af_router
  import hdlc_af_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  route_e       route,
  input  logic [W-1:0] data,
  input  logic [W-1:0] held,
  input  logic         stat_load,
  input  logic         stat_match_in,
  input  hit_e         stat_hit_in,
  input  logic         stat_cmd_in,
  output logic         addr_we,
  output logic [W-1:0] addr_data,
  output logic         ctrl_we,
  output logic [W-1:0] ctrl_data,
  output logic         fifo_we,
  output logic [W-1:0] fifo_data,
  output logic         stat_valid,
  output logic         stat_match,
  output logic [2:0]   stat_hit,
  output logic         stat_cmd
);
  logic go_addr, go_ctrl, go_fifo;
  assign go_addr = take && route == RT_ADDR;
  assign go_ctrl = take && route == RT_CTRL;
  assign go_fifo = take && route == RT_FIFO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_we    <= 1'b0;
      ctrl_we    <= 1'b0;
      fifo_we    <= 1'b0;
      addr_data  <= '0;
      ctrl_data  <= '0;
      fifo_data  <= '0;
      stat_valid <= 1'b0;
      stat_match <= 1'b0;
      stat_hit   <= HIT_NONE;
      stat_cmd   <= 1'b0;
    end else begin
      addr_we    <= go_addr;
      ctrl_we    <= go_ctrl;
      fifo_we    <= go_fifo;
      stat_valid <= stat_load;
      if (go_addr) addr_data <= held;
      if (go_ctrl) ctrl_data <= data;
      if (go_fifo) fifo_data <= data;
      if (stat_load) begin
        stat_match <= stat_match_in;
        stat_hit   <= stat_hit_in;
        stat_cmd   <= stat_cmd_in;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_addr_filter.sv
module hdlc_rx_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int unsigned W = BYTE_W,
  parameter logic [W-1:0] GRP_SAPI_A = 8'hFE,
  parameter logic [W-1:0] GRP_SAPI_B = 8'hFC,
  parameter logic [W-1:0] GRP_TEI    = 8'hFF,
  parameter int unsigned IDX_MAX     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sof,
  input  logic         in_eof,
  input  logic [W-1:0] in_data,
  input  logic [2:0]   mode,
  input  logic [W-1:0] sap1,
  input  logic [W-1:0] sap2,
  input  logic [W-1:0] tei1,
  input  logic [W-1:0] tei2,
  output logic         addr_we,
  output logic [W-1:0] addr_data,
  output logic         ctrl_we,
  output logic [W-1:0] ctrl_data,
  output logic         fifo_we,
  output logic [W-1:0] fifo_data,
  output logic         stat_valid,
  output logic         stat_match,
  output logic [2:0]   stat_hit,
  output logic         stat_cmd
);
  localparam int unsigned IW = $clog2(IDX_MAX + 1);
  localparam logic [IW-1:0] IDX_TOP = IW'(IDX_MAX);

  // frame state
  logic          in_frame_q;
  logic [IW-1:0] idx_q;
  logic [2:0]    mode_q;
  logic          acc_q;
  logic          len1_q;
  logic          sap_ok_q;
  logic [W-1:0]  held_q;
  hit_e          hit_q;
  logic          cmd_q;

  // named events for the checker
  logic          byte_take;
  logic [2:0]    eff_mode;
  logic [IW-1:0] eff_idx;
  logic          acc_prev;
  logic          len1_eff;
  logic          full_mode;

  assign byte_take = in_valid && (in_sof || in_frame_q);
  assign eff_mode  = in_sof ? mode : mode_q;
  assign eff_idx   = in_sof ? '0 : idx_q;
  assign acc_prev  = in_sof ? 1'b0 : acc_q;
  assign len1_eff  = in_sof ? in_data[0] : len1_q;
  assign full_mode = ~eff_mode[2];

  hit_e sap_hit, tei_hit;

  hdlc_af_sapi_cmp #(.W(W), .GRP_A(GRP_SAPI_A), .GRP_B(GRP_SAPI_B)) u_sapi (
    .byte_in (in_data),
    .sap1    (sap1),
    .sap2    (sap2),
    .masked  (full_mode),
    .use_grp (~full_mode),
    .hit     (sap_hit)
  );

  hdlc_af_tei_cmp #(.W(W), .GRP(GRP_TEI)) u_tei (
    .byte_in (in_data),
    .tei1    (tei1),
    .tei2    (tei2),
    .use_grp (eff_idx != '0),
    .hit     (tei_hit)
  );

  // per-byte decision and routing
  logic   dec_now, dec_ok, dec_cmd;
  hit_e   dec_hit;
  route_e route;
  logic   acc_eff;
  hit_e   hit_eff;
  logic   cmd_eff;

  always_comb begin
    dec_now = 1'b0;
    dec_ok  = 1'b0;
    dec_hit = HIT_NONE;
    dec_cmd = 1'b0;
    route   = RT_NONE;
    case (eff_mode)
      MODE_PASS: begin
        if (eff_idx == '0) begin
          dec_now = 1'b1;
          dec_ok  = 1'b1;
          dec_hit = HIT_ALL;
        end
        route = RT_FIFO;
      end
      MODE_SAPI: begin
        if (eff_idx == '0) begin
          dec_now = 1'b1;
          dec_ok  = sap_hit != HIT_NONE;
          dec_hit = sap_hit;
        end else if (acc_prev) begin
          route = RT_FIFO;
        end
      end
      MODE_TEI: begin
        if (eff_idx == IW'(1)) begin
          dec_now = 1'b1;
          dec_ok  = tei_hit != HIT_NONE;
          dec_hit = tei_hit;
          if (dec_ok) route = RT_ADDR;
        end else if (eff_idx == IW'(2)) begin
          if (acc_prev) route = RT_CTRL;
        end else if (eff_idx != '0) begin
          if (acc_prev) route = RT_FIFO;
        end
      end
      MODE_RSVD: begin
        if (eff_idx == '0) dec_now = 1'b1;
      end
      default: begin
        if (eff_idx == '0) begin
          if (len1_eff) begin
            dec_now = 1'b1;
            dec_ok  = tei_hit != HIT_NONE;
            dec_hit = tei_hit;
            dec_cmd = tei_hit == HIT_TEI1;
          end
        end else if (eff_idx == IW'(1)) begin
          if (len1_eff) begin
            if (acc_prev) route = RT_CTRL;
          end else begin
            dec_now = 1'b1;
            dec_ok  = sap_ok_q && tei_hit != HIT_NONE;
            dec_hit = tei_hit;
          end
        end else if (eff_idx == IW'(2)) begin
          if (acc_prev) route = len1_eff ? RT_FIFO : RT_CTRL;
        end else begin
          if (acc_prev) route = RT_FIFO;
        end
      end
    endcase
    acc_eff = dec_now ? dec_ok : acc_prev;
    hit_eff = acc_eff ? (dec_now ? dec_hit : hit_q) : HIT_NONE;
    cmd_eff = acc_eff && (dec_now ? dec_cmd : cmd_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
      mode_q     <= '0;
      acc_q      <= 1'b0;
      len1_q     <= 1'b0;
      sap_ok_q   <= 1'b0;
      held_q     <= '0;
      hit_q      <= HIT_NONE;
      cmd_q      <= 1'b0;
    end else if (byte_take) begin
      in_frame_q <= ~in_eof;
      idx_q      <= (eff_idx == IDX_TOP) ? IDX_TOP : eff_idx + IW'(1);
      mode_q     <= eff_mode;
      acc_q      <= acc_eff;
      if (eff_idx == '0) begin
        held_q   <= in_data;
        len1_q   <= in_data[0];
        sap_ok_q <= sap_hit != HIT_NONE;
      end
      if (dec_now) begin
        hit_q <= dec_hit;
        cmd_q <= dec_cmd;
      end
    end
  end

  hdlc_af_router #(.W(W)) u_router (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (byte_take),
    .route         (route),
    .data          (in_data),
    .held          (held_q),
    .stat_load     (byte_take && in_eof),
    .stat_match_in (acc_eff),
    .stat_hit_in   (hit_eff),
    .stat_cmd_in   (cmd_eff),
    .addr_we       (addr_we),
    .addr_data     (addr_data),
    .ctrl_we       (ctrl_we),
    .ctrl_data     (ctrl_data),
    .fifo_we       (fifo_we),
    .fifo_data     (fifo_data),
    .stat_valid    (stat_valid),
    .stat_match    (stat_match),
    .stat_hit      (stat_hit),
    .stat_cmd      (stat_cmd)
  );
endmodule

// File: rtl/hdlc_af_chk.sv
module hdlc_af_chk
  import hdlc_af_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_eof,
  input logic [7:0] in_data,
  input logic       byte_take,
  input logic [2:0] eff_mode,
  input logic       addr_we,
  input logic       ctrl_we,
  input logic       fifo_we,
  input logic [7:0] fifo_data,
  input logic       stat_valid,
  input logic       stat_match,
  input logic [2:0] stat_hit,
  input logic       stat_cmd
);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_we, ctrl_we, fifo_we}));

  a_r2_write_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we || ctrl_we || fifo_we) |-> $past(byte_take));

  a_r11_status_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(byte_take && in_eof));

  a_r10_discard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !stat_match) |-> !(addr_we || ctrl_we || fifo_we));

  a_r11_hit_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_match == (stat_hit != 3'd0)));

  a_r8_cmd_only_tei1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_cmd |-> stat_hit == 3'd4);

  a_r6_addr_only_tei_mode: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |-> $past(eff_mode) == MODE_TEI);

  a_r4_pass_all_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && eff_mode == MODE_PASS) |=> (fifo_we && fifo_data == $past(in_data)));
endmodule

bind hdlc_rx_addr_filter hdlc_af_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_eof     (in_eof),
  .in_data    (in_data),
  .byte_take  (byte_take),
  .eff_mode   (eff_mode),
  .addr_we    (addr_we),
  .ctrl_we    (ctrl_we),
  .fifo_we    (fifo_we),
  .fifo_data  (fifo_data),
  .stat_valid (stat_valid),
  .stat_match (stat_match),
  .stat_hit   (stat_hit),
  .stat_cmd   (stat_cmd)
);

// File: tb/hdlc_rx_addr_filter_tb.sv
module hdlc_rx_addr_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [2:0] mode = 3'b110;
  logic [7:0] sap1 = 8'h10, sap2 = 8'h24, tei1 = 8'h81, tei2 = 8'h43;
  logic addr_we, ctrl_we, fifo_we, stat_valid, stat_match, stat_cmd;
  logic [7:0] addr_data, ctrl_data, fifo_data;
  logic [2:0] stat_hit;

  always #5 clk = ~clk;

  hdlc_rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .mode(mode), .sap1(sap1),
    .sap2(sap2), .tei1(tei1), .tei2(tei2), .addr_we(addr_we),
    .addr_data(addr_data), .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
    .fifo_we(fifo_we), .fifo_data(fifo_data), .stat_valid(stat_valid),
    .stat_match(stat_match), .stat_hit(stat_hit), .stat_cmd(stat_cmd)
  );

  int n_tests = 0;
  int n_fail = 0;

  // output monitor, sampled on the falling edge
  logic [7:0] fifo_log [0:255];
  int fifo_n = 0, ctrl_n = 0, addr_n = 0, stat_n = 0;
  logic [7:0] ctrl_last = 8'h00, addr_last = 8'h00;
  logic s_match = 1'b0, s_cmd = 1'b0;
  logic [2:0] s_hit = 3'd0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_we) begin
        fifo_log[fifo_n[7:0]] = fifo_data;
        fifo_n = fifo_n + 1;
      end
      if (ctrl_we) begin
        ctrl_last = ctrl_data;
        ctrl_n = ctrl_n + 1;
      end
      if (addr_we) begin
        addr_last = addr_data;
        addr_n = addr_n + 1;
      end
      if (stat_valid) begin
        s_match = stat_match;
        s_hit = stat_hit;
        s_cmd = stat_cmd;
        stat_n = stat_n + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] fr [0:15];
  int fr_n = 0;
  int b_fifo, b_ctrl, b_addr, b_stat;

  task automatic snap();
    b_fifo = fifo_n; b_ctrl = ctrl_n; b_addr = addr_n; b_stat = stat_n;
  endtask

  // drive a frame; bytes after the first use m_rest as the mode input
  task automatic run_frame(input logic [2:0] m_first, input logic [2:0] m_rest);
    snap();
    for (int i = 0; i < fr_n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == fr_n - 1);
      in_data = fr[i];
      mode = (i == 0) ? m_first : m_rest;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_frame(input string req,
                             input int e_addr_n, input logic [7:0] e_addr,
                             input int e_ctrl_n, input logic [7:0] e_ctrl,
                             input int e_fifo_n, input int fifo_from,
                             input logic e_match, input logic [2:0] e_hit,
                             input logic e_cmd);
    chk({req, " status count"}, stat_n - b_stat, 1);
    chk({req, " addr writes"}, addr_n - b_addr, e_addr_n);
    if (e_addr_n > 0) chk({req, " addr data"}, addr_last, e_addr);
    chk({req, " ctrl writes"}, ctrl_n - b_ctrl, e_ctrl_n);
    if (e_ctrl_n > 0) chk({req, " ctrl data"}, ctrl_last, e_ctrl);
    chk({req, " fifo writes"}, fifo_n - b_fifo, e_fifo_n);
    if (fifo_n - b_fifo == e_fifo_n)
      for (int j = 0; j < e_fifo_n; j++)
        chk({req, " fifo data"}, fifo_log[(b_fifo + j) % 256], fr[fifo_from + j]);
    chk({req, " match"}, s_match, e_match);
    chk({req, " hit"}, s_hit, e_hit);
    chk({req, " cmd"}, s_cmd, e_cmd);
  endtask

  task automatic set4(input int n, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] c, input logic [7:0] d, input logic [7:0] e);
    fr_n = n; fr[0] = a; fr[1] = b; fr[2] = c; fr[3] = d; fr[4] = e;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 strobes", {addr_we, ctrl_we, fifo_we, stat_valid}, 4'b0);
    chk("R1 status", {stat_match, stat_hit, stat_cmd}, 5'b0);
  endtask

  task automatic t_pass();
    set4(4, 8'h55, 8'h12, 8'h34, 8'h9A, 8'h00);
    run_frame(3'b110, 3'b110);
    check_frame("R4 pass-all", 0, 0, 0, 0, 4, 0, 1'b1, 3'd7, 1'b0);
  endtask

  task automatic t_sapi();
    set4(4, 8'h10, 8'hA1, 8'hA2, 8'hA3, 8'h00);
    run_frame(3'b111, 3'b111);
    check_frame("R5 sapi own", 0, 0, 0, 0, 3, 1, 1'b1, 3'd1, 1'b0);
    set4(3, 8'hFC, 8'hB1, 8'hB2, 8'h00, 8'h00);
    run_frame(3'b111, 3'b111);
    check_frame("R5 sapi group", 0, 0, 0, 0, 2, 1, 1'b1, 3'd3, 1'b0);
    set4(3, 8'h11, 8'hB1, 8'hB2, 8'h00, 8'h00);
    run_frame(3'b111, 3'b111);
    check_frame("R10 sapi miss", 0, 0, 0, 0, 0, 0, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_tei();
    set4(5, 8'h3C, 8'h43, 8'hC5, 8'hD1, 8'hD2);
    run_frame(3'b101, 3'b101);
    check_frame("R6 tei2", 1, 8'h3C, 1, 8'hC5, 2, 3, 1'b1, 3'd5, 1'b0);
    set4(3, 8'h3E, 8'hFF, 8'h77, 8'h00, 8'h00);
    run_frame(3'b101, 3'b101);
    check_frame("R6 tei group", 1, 8'h3E, 1, 8'h77, 0, 0, 1'b1, 3'd6, 1'b0);
    set4(4, 8'h3C, 8'h44, 8'h01, 8'h02, 8'h00);
    run_frame(3'b101, 3'b101);
    check_frame("R10 tei miss", 0, 0, 0, 0, 0, 0, 1'b0, 3'd0, 1'b0);
    set4(1, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00);
    run_frame(3'b101, 3'b101);
    check_frame("R10 tei short", 0, 0, 0, 0, 0, 0, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_full1();
    set4(4, 8'h81, 8'h11, 8'h22, 8'h33, 8'h00);
    run_frame(3'b010, 3'b010);
    check_frame("R8 one-byte command", 0, 0, 1, 8'h11, 2, 2, 1'b1, 3'd4, 1'b1);
    set4(3, 8'h43, 8'h11, 8'h22, 8'h00, 8'h00);
    run_frame(3'b011, 3'b011);
    check_frame("R8 one-byte response", 0, 0, 1, 8'h11, 1, 2, 1'b1, 3'd5, 1'b0);
    set4(3, 8'hFF, 8'h11, 8'h22, 8'h00, 8'h00);
    run_frame(3'b010, 3'b010);
    check_frame("R8 one-byte no group", 0, 0, 0, 0, 0, 0, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_full2();
    set4(5, 8'h26, 8'h81, 8'h61, 8'h62, 8'h63);
    run_frame(3'b011, 3'b011);
    check_frame("R9 two-byte masked sap", 0, 0, 1, 8'h61, 2, 3, 1'b1, 3'd4, 1'b0);
    set4(3, 8'h12, 8'hFF, 8'h61, 8'h00, 8'h00);
    run_frame(3'b010, 3'b010);
    check_frame("R9 two-byte group tei", 0, 0, 1, 8'h61, 0, 0, 1'b1, 3'd6, 1'b0);
    set4(4, 8'h30, 8'h81, 8'h61, 8'h62, 8'h00);
    run_frame(3'b010, 3'b010);
    check_frame("R10 two-byte sap miss", 0, 0, 0, 0, 0, 0, 1'b0, 3'd0, 1'b0);
    set4(4, 8'h10, 8'h82, 8'h61, 8'h62, 8'h00);
    run_frame(3'b010, 3'b010);
    check_frame("R7 two-byte tei miss", 0, 0, 0, 0, 0, 0, 1'b0, 3'd0, 1'b0);
    set4(1, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
    run_frame(3'b010, 3'b010);
    check_frame("R10 two-byte short", 0, 0, 0, 0, 0, 0, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_rsvd();
    set4(3, 8'h10, 8'h81, 8'h11, 8'h00, 8'h00);
    run_frame(3'b100, 3'b100);
    check_frame("R12 reserved", 0, 0, 0, 0, 0, 0, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_mode_change();
    set4(3, 8'h11, 8'h21, 8'h22, 8'h00, 8'h00);
    run_frame(3'b111, 3'b110);
    check_frame("R13 sapi then pass", 0, 0, 0, 0, 0, 0, 1'b0, 3'd0, 1'b0);
    set4(3, 8'h11, 8'h21, 8'h22, 8'h00, 8'h00);
    run_frame(3'b110, 3'b111);
    check_frame("R13 pass then sapi", 0, 0, 0, 0, 3, 0, 1'b1, 3'd7, 1'b0);
  endtask

  task automatic t_outside();
    snap();
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1; in_data = 8'h5A; mode = 3'b110;
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 outside frame writes", (fifo_n - b_fifo) + (ctrl_n - b_ctrl) + (addr_n - b_addr), 0);
    chk("R2 outside frame status", stat_n - b_stat, 0);
  endtask

  task automatic t_strobe_timing();
    // R3: the FIFO strobe rises one cycle after the first pass-all byte
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'hE7; mode = 3'b110;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk("R3 strobe one cycle later", fifo_we, 1'b1);
    chk("R3 strobe data", fifo_data, 8'hE7);
    chk("R11 status with end byte", stat_valid, 1'b1);
    @(negedge clk);
    chk("R3 strobe one cycle wide", fifo_we, 1'b0);
    chk("R11 status pulse one cycle", stat_valid, 1'b0);
    chk("R11 status held", stat_hit, 3'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 under reset", {addr_we, ctrl_we, fifo_we, stat_valid}, 4'b0);
    rst_n = 1'b1;
    t_reset();
    t_pass();
    t_sapi();
    t_tei();
    t_full1();
    t_full2();
    t_rsvd();
    t_mode_change();
    t_outside();
    t_strobe_timing();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule